// File: doc/BRIEF.md
# Processor Reset Guard with Fail-Safe Latch

This block drives the processor reset and halt lines of a plug-in module. Both lines are modelled as open-drain pins: the block outputs a drive-low enable for each and reads the reset pin back. Three sources pull the lines low. The first is the logic supply monitor, through a rail-good input. The second is an external reset request. The third is the backplane pair of module-select and module-reset, which counts only when both are high together. Each source has its own minimum hold time, so a short glitch still gives a complete reset.

A fail-safe latch catches a low-true output from the processor watchdog. Once set, the latch blocks the serial data transmitter. It stays set until the module is reset, either by a power-on reset or by an external reset. Rail-good works as the block's asynchronous power-on reset. The other asynchronous inputs pass through synchronizer chains before use.

Top module: `core_reset_guard`

## Requirements
- R1: While railGood is low, resetDriveLow and haltDriveLow are both 1 at once, without waiting for a clock edge.
- R2: After railGood rises, the lines stay driven for at least CLK_KHZ*RAIL_HOLD_MS cycles. The timing starts after the synchronizer stages. If the rail drops again during this hold, the count starts over from the next rise.
- R3: A high level on extResetReq drives the lines. They stay driven for at least EXT_HOLD_CYCLES (default 24) cycles after the request ends, with synchronizer latency added.
- R4: modSelect and modReset, both active high, cause the same hold as R3 only when both are high together. Either one alone leaves the lines released.
- R5: A low level on the resetPinN readback counts as an external reset and starts the R3 hold. This applies only while the block has not itself driven the pin within the last SYNC_STAGES+1 cycles.
- R6: A low level on wdogN at a clock edge, while no reset is being driven, sets failSafe at that edge. txEnable is then 0.
- R7: failSafe stays set after wdogN returns high. Only a reset clears it: a power-on reset (railGood low) or any hold from R3, R4 or R5.
- R8: haltDriveLow always equals resetDriveLow.
- R9: When failSafe is 0, txEnable follows txRequest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| railGood | input | 1 | Logic rail in specification; low acts as asynchronous power-on reset |
| extResetReq | input | 1 | External reset request, active high, asynchronous |
| modSelect | input | 1 | Module select, active high, asynchronous |
| modReset | input | 1 | Module reset, active high, asynchronous |
| resetPinN | input | 1 | Readback of the processor reset pin level |
| wdogN | input | 1 | Watchdog timeout, low true |
| txRequest | input | 1 | Transmitter enable request from the processor |
| resetDriveLow | output | 1 | Pull the reset pin low |
| haltDriveLow | output | 1 | Pull the halt pin low |
| failSafe | output | 1 | Fail-safe latch state |
| txEnable | output | 1 | Transmitter enable after the fail-safe gate |

## Verification
Some checks run on every clock edge. These cover: the drive while the rail is down, the count-up step of the rail timer and its restart, the reload and count-down of the external timer, the latch setting on a watchdog strobe, and the latch holding until a reset is driven. Other behaviour can only be shown by the bench scenarios. These are the total length of each hold as seen at the pins, the rule that select and reset must both be high, the readback path with its self-masking window, and the latch clearing and the transmitter returning after a reset.

// File: rtl/rg_pkg.sv
package rg_pkg;
  // strobes from the control side to the hold timers
  typedef struct packed {
    logic railOk;   // rail good, synchronized
    logic extLoad;  // reload the external hold timer
  } guardStrobe_t;
endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rg_ctrl.sv
module rg_ctrl
  import rg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         railGood,
  input  logic         extResetReq,
  input  logic         modSelect,
  input  logic         modReset,
  input  logic         resetPinN,
  input  logic         wdogN,
  input  logic         driveLow,
  output guardStrobe_t strobe,
  output logic         failSafe
);
  localparam int NUM_REQ  = 3;
  localparam int HIST_LEN = SYNC_STAGES;

  logic [NUM_REQ-1:0] reqRaw, reqSync;
  logic railOkSync, pinSync;
  logic [HIST_LEN-1:0] driveHist;
  logic selfMask, outsidePull, hwPair, latchQ;

  // rail-good bridge: asynchronous assert, synchronized release
  rg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) railBridge (
    .clk(clk), .arstN(railGood), .d(1'b1), .q(railOkSync));

  assign reqRaw = {extResetReq, modSelect, modReset};

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_reqSync
    rg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) reqSyncI (
      .clk(clk), .arstN(railGood), .d(reqRaw[i]), .q(reqSync[i]));
  end

  rg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) pinSyncI (
    .clk(clk), .arstN(railGood), .d(resetPinN), .q(pinSync));

  // own drive history masks the readback until the pin has settled
  always_ff @(posedge clk or negedge railGood) begin
    if (!railGood) driveHist <= '1;
    else           driveHist <= {driveHist[HIST_LEN-2:0], driveLow};
  end

  assign selfMask    = driveLow | (|driveHist);
  assign outsidePull = !pinSync && !selfMask;
  assign hwPair      = reqSync[1] && reqSync[0];

  assign strobe.railOk  = railOkSync;
  assign strobe.extLoad = reqSync[2] | hwPair | outsidePull;

  // fail-safe latch: any driven reset clears, watchdog strobe sets
  always_ff @(posedge clk or negedge railGood) begin
    if (!railGood)   latchQ <= 1'b0;
    else if (driveLow) latchQ <= 1'b0;
    else if (!wdogN) latchQ <= 1'b1;
  end

  assign failSafe = latchQ;

  // R6
  wdog_sets_latch_chk: assert property (@(posedge clk) disable iff (!railGood)
    (!wdogN && !driveLow) |=> failSafe);

  // R7
  latch_persist_chk: assert property (@(posedge clk) disable iff (!railGood)
    (failSafe && !driveLow) |=> failSafe);
endmodule

// File: rtl/rg_timers.sv
module rg_timers
  import rg_pkg::*;
#(
  parameter int RAIL_CYCLES = 100,
  parameter int EXT_CYCLES  = 24
) (
  input  logic         clk,
  input  logic         railGood,
  input  guardStrobe_t strobe,
  output logic         driveLow
);
  localparam int RW = $clog2(RAIL_CYCLES + 1);
  localparam int EW = $clog2(EXT_CYCLES + 1);
  localparam logic [RW-1:0] RAIL_END = RW'(RAIL_CYCLES);
  localparam logic [EW-1:0] EXT_END  = EW'(EXT_CYCLES);

  logic [RW-1:0] railCnt;
  logic [EW-1:0] extCnt;
  logic railBusy, extBusy;

  // rail hold: counts up from zero while the rail stays good
  always_ff @(posedge clk or negedge railGood) begin
    if (!railGood)           railCnt <= '0;
    else if (!strobe.railOk) railCnt <= '0;
    else if (railBusy)       railCnt <= railCnt + 1'b1;
  end

  // external hold: reloads while requested, then counts down
  always_ff @(posedge clk or negedge railGood) begin
    if (!railGood)          extCnt <= '0;
    else if (strobe.extLoad) extCnt <= EXT_END;
    else if (extBusy)       extCnt <= extCnt - 1'b1;
  end

  assign railBusy = (railCnt != RAIL_END);
  assign extBusy  = (extCnt != '0);
  assign driveLow = railBusy | extBusy;

  // R2
  rail_step_chk: assert property (@(posedge clk) disable iff (!railGood)
    (strobe.railOk && railBusy) |=> (railCnt == $past(railCnt) + 1'b1));

  // R2
  rail_restart_chk: assert property (@(posedge clk) disable iff (!railGood)
    !strobe.railOk |=> (railCnt == '0));

  // R3
  ext_reload_chk: assert property (@(posedge clk) disable iff (!railGood)
    strobe.extLoad |=> (extCnt == EXT_END));

  // R3
  ext_countdown_chk: assert property (@(posedge clk) disable iff (!railGood)
    (extBusy && !strobe.extLoad) |=> (extCnt == $past(extCnt) - 1'b1));
endmodule

// File: rtl/core_reset_guard.sv
module core_reset_guard
  import rg_pkg::*;
#(
  parameter int CLK_KHZ         = 200000,
  parameter int RAIL_HOLD_MS    = 130,
  parameter int EXT_HOLD_CYCLES = 24,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic railGood,
  input  logic extResetReq,
  input  logic modSelect,
  input  logic modReset,
  input  logic resetPinN,
  input  logic wdogN,
  input  logic txRequest,
  output logic resetDriveLow,
  output logic haltDriveLow,
  output logic failSafe,
  output logic txEnable
);
  localparam int RAIL_CYCLES = CLK_KHZ * RAIL_HOLD_MS;

  guardStrobe_t strobe;
  logic driveLow;

  rg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .railGood(railGood), .extResetReq(extResetReq),
    .modSelect(modSelect), .modReset(modReset), .resetPinN(resetPinN),
    .wdogN(wdogN), .driveLow(driveLow), .strobe(strobe), .failSafe(failSafe));

  rg_timers #(.RAIL_CYCLES(RAIL_CYCLES), .EXT_CYCLES(EXT_HOLD_CYCLES)) timers (
    .clk(clk), .railGood(railGood), .strobe(strobe), .driveLow(driveLow));

  assign resetDriveLow = driveLow;
  assign haltDriveLow  = driveLow;
  assign txEnable      = txRequest & ~failSafe;

  // R1
  always @(posedge clk) begin
    if (!railGood) begin
      rail_low_drive_chk: assert (resetDriveLow && haltDriveLow);
    end
  end
endmodule

// File: tb/core_reset_guard_test.sv
`timescale 1ns/1ps
module core_reset_guard_test;
  localparam int CLK_KHZ  = 50;
  localparam int HOLD_MS  = 2;
  localparam int RAIL_CYC = CLK_KHZ * HOLD_MS;
  localparam int EXT_CYC  = 24;

  logic clk = 1'b0;
  logic railGood = 1'b1;
  logic extResetReq = 1'b0, modSelect = 1'b0, modReset = 1'b0;
  logic wdogN = 1'b1, txRequest = 1'b0, outsidePull = 1'b0;
  logic resetPinN, resetDriveLow, haltDriveLow, failSafe, txEnable;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign resetPinN = !(resetDriveLow | outsidePull);

  core_reset_guard #(.CLK_KHZ(CLK_KHZ), .RAIL_HOLD_MS(HOLD_MS),
                     .EXT_HOLD_CYCLES(EXT_CYC), .SYNC_STAGES(2)) uut (
    .clk(clk), .railGood(railGood), .extResetReq(extResetReq),
    .modSelect(modSelect), .modReset(modReset), .resetPinN(resetPinN),
    .wdogN(wdogN), .txRequest(txRequest), .resetDriveLow(resetDriveLow),
    .haltDriveLow(haltDriveLow), .failSafe(failSafe), .txEnable(txEnable));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // waits up to 6 cycles for the drive, then counts driven samples
  task automatic measureLow(output int n, output bit haltOk);
    int w = 0;
    n = 0; haltOk = 1'b1;
    while (!resetDriveLow && w < 6) begin cycles(1); w++; end
    while (resetDriveLow && n < 2000) begin
      if (haltDriveLow != resetDriveLow) haltOk = 1'b0;
      n++;
      cycles(1);
    end
  endtask

  task automatic testPowerOn();
    int n; bit h;
    cycles(1);
    check(resetDriveLow && haltDriveLow, "R1", "drive while rail low", resetDriveLow, 1);
    check(failSafe == 1'b0, "R7", "latch clear at power-on", failSafe, 0);
    cycles(5);
    check(resetDriveLow == 1'b1, "R1", "drive held while rail low", resetDriveLow, 1);
    railGood = 1'b1;
    measureLow(n, h);
    check(n >= RAIL_CYC && n <= RAIL_CYC + 4, "R2", "rail hold length", n, RAIL_CYC);
    check(h, "R8", "halt tracks reset in rail hold", h, 1);
  endtask

  task automatic testRailRestart();
    int n; bit h;
    railGood = 1'b0; #1;
    check(resetDriveLow == 1'b1, "R1", "immediate drive on rail drop", resetDriveLow, 1);
    cycles(2);
    railGood = 1'b1;
    cycles(RAIL_CYC / 2);
    railGood = 1'b0;
    cycles(1);
    railGood = 1'b1;
    measureLow(n, h);
    check(n >= RAIL_CYC && n <= RAIL_CYC + 4, "R2", "hold restarts after dropout", n, RAIL_CYC);
  endtask

  task automatic testExtPulse();
    int n; bit h;
    extResetReq = 1'b1; cycles(1); extResetReq = 1'b0;
    measureLow(n, h);
    check(n >= EXT_CYC && n <= EXT_CYC + 4, "R3", "external hold length", n, EXT_CYC);
    check(h, "R8", "halt tracks reset in external hold", h, 1);
    cycles(4);
  endtask

  task automatic testSelectPair();
    int n; bit h; bit seen;
    seen = 1'b0;
    modSelect = 1'b1;
    for (int i = 0; i < 10; i++) begin cycles(1); if (resetDriveLow) seen = 1'b1; end
    modSelect = 1'b0;
    check(!seen, "R4", "select alone leaves lines released", seen, 0);
    seen = 1'b0;
    modReset = 1'b1;
    for (int i = 0; i < 10; i++) begin cycles(1); if (resetDriveLow) seen = 1'b1; end
    check(!seen, "R4", "module reset alone leaves lines released", seen, 0);
    modSelect = 1'b1; cycles(3);
    modSelect = 1'b0; modReset = 1'b0;
    measureLow(n, h);
    check(n >= EXT_CYC && n <= EXT_CYC + 4, "R4", "pair hold length", n, EXT_CYC);
    cycles(4);
  endtask

  task automatic testOutsidePull();
    int n; bit h; bit seen;
    outsidePull = 1'b1; cycles(3); outsidePull = 1'b0;
    measureLow(n, h);
    check(n >= EXT_CYC - 2 && n <= EXT_CYC + 4, "R5", "readback pull starts hold", n, EXT_CYC);
    seen = 1'b0;
    for (int i = 0; i < 15; i++) begin cycles(1); if (resetDriveLow) seen = 1'b1; end
    check(!seen, "R5", "own release not taken as outside pull", seen, 0);
  endtask

  task automatic testWatchdog();
    txRequest = 1'b1; cycles(1);
    check(txEnable == 1'b1, "R9", "tx follows request when latch clear", txEnable, 1);
    wdogN = 1'b0; cycles(1); wdogN = 1'b1;
    check(failSafe == 1'b1, "R6", "watchdog sets latch", failSafe, 1);
    check(txEnable == 1'b0, "R6", "latch blocks tx", txEnable, 0);
    cycles(20);
    check(failSafe == 1'b1, "R7", "latch persists after watchdog release", failSafe, 1);
    check(resetDriveLow == 1'b0, "R7", "watchdog alone drives no reset", resetDriveLow, 0);
  endtask

  task automatic testClearByExt();
    int n; bit h;
    extResetReq = 1'b1; cycles(1); extResetReq = 1'b0;
    measureLow(n, h);
    cycles(1);
    check(failSafe == 1'b0, "R7", "external reset clears latch", failSafe, 0);
    check(txEnable == 1'b1, "R9", "tx returns after clear", txEnable, 1);
    txRequest = 1'b0; cycles(1);
    check(txEnable == 1'b0, "R9", "tx follows request low", txEnable, 0);
  endtask

  task automatic testClearByPairAndRail();
    int n; bit h;
    wdogN = 1'b0; cycles(1); wdogN = 1'b1;
    check(failSafe == 1'b1, "R6", "latch set again", failSafe, 1);
    modSelect = 1'b1; modReset = 1'b1; cycles(3);
    modSelect = 1'b0; modReset = 1'b0;
    measureLow(n, h); cycles(1);
    check(failSafe == 1'b0, "R7", "pair reset clears latch", failSafe, 0);
    wdogN = 1'b0; cycles(1); wdogN = 1'b1;
    railGood = 1'b0; #1;
    check(failSafe == 1'b0, "R7", "power-on reset clears latch", failSafe, 0);
    cycles(2);
    railGood = 1'b1;
    measureLow(n, h);
    check(failSafe == 1'b0, "R7", "latch clear after rail hold", failSafe, 0);
  endtask

  initial begin
    #1 railGood = 1'b0;
    @(negedge clk);
    testPowerOn();
    testRailRestart();
    testExtPulse();
    testSelectPair();
    testOutsidePull();
    testWatchdog();
    testClearByExt();
    testClearByPairAndRail();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule